// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a 512-byte serial memory reached over a two-wire bus with open-drain signalling. A faster system clock oversamples the bus clock and data lines through synchronizers. The block recognises bus start and stop conditions, shifts bytes in and out, and answers each byte on the ninth bus clock. It drives one output, an enable that pulls the data line low.

A protocol engine decodes the device byte and runs the transfer. This covers single-byte and page writes, reads from the current pointer, random reads (a word address, then a repeated start with the read bit set) and sequential reads. The engine sends strobes to a storage unit. That unit holds the address pointer, a one-page staging buffer, the array (modelled as registers, cleared by reset) and the write-cycle timer. While a write cycle runs the device ignores every address byte, so a bus master can poll for completion.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data-line pull-down is released and no write cycle is running, so the first device byte is acknowledged.
- R2: A device byte is acknowledged (data line low on the ninth clock) only when bits 7..4 are 1010 and bits 3..2 are 00. Any other value gets no acknowledge, and the device stays silent until the next start.
- R3: In the device byte, bit 1 is address bit 8 and bit 0 is the direction (0 = write). After a write device byte, the next byte is loaded as address bits 7..0 and acknowledged. Ending there with a stop starts no write cycle and leaves the pointer at the loaded address.
- R4: Each data byte is acknowledged and staged at the pointer's low 4 bits. Those 4 bits then advance and wrap inside the 16-byte page, so a later byte for the same location replaces an earlier one. The staged bytes reach the array only after a stop.
- R5: A stop with at least one staged byte starts a write cycle of WRITE_CYCLES system clocks. During the cycle every device byte goes unacknowledged. Once it ends, the data can be read back.
- R6: After a write of n bytes from address A, the pointer holds A's page with low bits (A + n) mod 16.
- R7: A read device byte (bit 0 = 1) is acknowledged. The device then returns the byte at the pointer, MSB first, and the pointer advances by one, wrapping from 511 to 0. Bit 1 of a read device byte is ignored.
- R8: An acknowledge from the master on the ninth clock of a read byte brings the next byte. No acknowledge, followed by a stop, ends the read.
- R9: A start in any state restarts device-byte reception. Data bytes followed by a repeated start instead of a stop are dropped and never written.
- R10: A start, nine clocks with the data line high, then another start drops any partial command. During a write cycle this sequence does not affect the cycle.
- R11: The pull-down changes to active only while the bus clock is low, and a stop releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with a 16-byte page and a write cycle of 1000 system clocks. With a cycle that short, the bench can see a poll go unacknowledged and then see the later poll that succeeds within the same run. It sweeps all 64 values of the upper six device-byte bits, and runs page writes at a range of start offsets and lengths, including a length that wraps inside the page, a full page and a single byte at the last address of a page. Each write is checked both through the pointer it leaves behind and through a full read-back of the page. A sequential read across the top of the array and a software reset during a running write cycle cover the remaining corners.

// File: rtl/twi_ee_pkg.sv
// Shared constants and types for the two-wire EEPROM slave.
// Assumes a 512-byte array, so one high address bit is carried in the device byte.
package twi_ee_pkg;
    localparam int          EE_AW     = 9;        // array address width
    localparam logic [3:0]  EE_FAMILY = 4'b1010;  // fixed device code
    localparam logic [1:0]  EE_SEL    = 2'b00;    // fixed select bits

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVICE,
        PH_WORD,
        PH_DATA,
        PH_READ
    } phase_t;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronises the bus clock and data lines into the system clock domain.
// Produces level, clock-edge and start/stop events from the synchronised samples.
// Assumes SYNC_STAGES >= 2 and a system clock several times the bus clock.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[SYNC_STAGES-1];
    assign sda_lvl   = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twi_ee_store.sv
// Address pointer, one-page staging buffer, register array and write-cycle timer.
// Driven by single-cycle command strobes from the protocol engine.
// Assumes commands never arrive while busy (the engine refuses all devices then).
module twi_ee_store
    import twi_ee_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_load,
    input  logic       cmd_put,
    input  logic       cmd_get,
    input  logic       cmd_launch,
    input  logic       a8,
    input  logic [7:0] wbyte,
    output logic [7:0] rd_data,
    output logic       busy
);
    localparam int MEM_BYTES = 1 << EE_AW;
    localparam int PW        = $clog2(PAGE_BYTES);
    localparam int CW        = $clog2(WRITE_CYCLES + 1);

    logic [EE_AW-1:0]    ptr;
    logic [7:0]          mem  [MEM_BYTES];
    logic [7:0]          pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [EE_AW-PW-1:0] wpage;
    logic [CW-1:0]       tmr;
    logic                commit;

    assign commit  = busy && (tmr == '0);
    assign rd_data = mem[ptr];

    // Pointer: loaded by word address, wraps in page on writes, linear on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (cmd_load) begin
            ptr <= {a8, wbyte};
        end else if (cmd_put) begin
            ptr <= {ptr[EE_AW-1:PW], ptr[PW-1:0] + PW'(1)};
        end else if (cmd_get) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Staging buffer: cleared on a new word address, last write to a slot wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
        end else if (cmd_load) begin
            pmask <= '0;
        end else if (cmd_put) begin
            pbuf[ptr[PW-1:0]]  <= wbyte;
            pmask[ptr[PW-1:0]] <= 1'b1;
        end
    end

    // Write-cycle timer: starts on a stop with staged data, counts down to commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tmr   <= '0;
            wpage <= '0;
        end else if (cmd_launch && (|pmask) && !busy) begin
            busy  <= 1'b1;
            tmr   <= CW'(WRITE_CYCLES - 1);
            wpage <= ptr[EE_AW-1:PW];
        end else if (commit) begin
            busy <= 1'b0;
        end else if (busy) begin
            tmr <= tmr - 1'b1;
        end
    end

    // Array: staged bytes copied into the selected page at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pmask[i]) mem[{wpage, PW'(i)}] <= pbuf[i];
            end
        end
    end
endmodule

// File: rtl/twi_ee_proto.sv
// Bus protocol engine: frames 9-clock byte slots, decodes the device byte,
// acknowledges, serialises read data and issues strobes to the store.
// Assumes event inputs from twi_line_sync; start/stop never coincide with clock edges.
module twi_ee_proto
    import twi_ee_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       sda_lvl,
    input  logic       busy,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       cmd_load,
    output logic       cmd_put,
    output logic       cmd_get,
    output logic       cmd_launch,
    output logic       a8,
    output logic [7:0] rx_byte
);
    phase_t     ph;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic       byte_done;
    logic       ack_done;
    logic       dev_hit;

    assign byte_done  = scl_fall && (bitcnt == 4'd8);
    assign ack_done   = scl_fall && (bitcnt == 4'd9);
    assign dev_hit    = (shreg[7:4] == EE_FAMILY) && (shreg[3:2] == EE_SEL) && !busy;
    assign cmd_load   = byte_done && (ph == PH_WORD);
    assign cmd_put    = byte_done && (ph == PH_DATA);
    assign cmd_get    = ack_done && (ph == PH_READ);
    assign cmd_launch = stop_evt && (ph == PH_DATA);
    assign rx_byte    = shreg;

    // Bit slot counter and input shifter: 8 data rises, then the ninth (ack) rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
        end else if (start_evt || stop_evt) begin
            bitcnt <= '0;
        end else if (scl_rise && (bitcnt <= 4'd8)) begin
            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
        end else if (ack_done) begin
            bitcnt <= '0;
        end
    end

    // Transfer phase: device decode, word address, data, read; master NACK ends a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
            a8 <= 1'b0;
        end else if (start_evt) begin
            ph <= PH_DEVICE;
        end else if (stop_evt) begin
            ph <= PH_IDLE;
        end else if (byte_done) begin
            case (ph)
                PH_DEVICE: begin
                    if (!dev_hit)      ph <= PH_IDLE;
                    else if (shreg[0]) ph <= PH_READ;
                    else begin
                        ph <= PH_WORD;
                        a8 <= shreg[1];
                    end
                end
                PH_WORD: ph <= PH_DATA;
                default: ph <= ph;
            endcase
        end else if (scl_rise && (bitcnt == 4'd8) && (ph == PH_READ) && sda_lvl) begin
            ph <= PH_IDLE;
        end
    end

    // Data-line pull-down: ack slot for received bytes, serial bits for read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            txreg  <= '0;
        end else if (start_evt || stop_evt) begin
            sda_oe <= 1'b0;
        end else if (byte_done) begin
            sda_oe <= ((ph == PH_DEVICE) && dev_hit) || (ph == PH_WORD) || (ph == PH_DATA);
        end else if (ack_done) begin
            if (ph == PH_READ) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
            end else begin
                sda_oe <= 1'b0;
            end
        end else if (scl_fall && (ph == PH_READ) && (bitcnt >= 4'd1) && (bitcnt <= 4'd7)) begin
            sda_oe <= ~txreg[3'(4'd7 - bitcnt)];
        end
    end
endmodule

// File: rtl/twi_eeprom_slave.sv
// Top of the two-wire EEPROM slave: line synchroniser, protocol engine and store.
// Assumes an external pull-up on both lines; sda_oe = 1 pulls the data line low.
module twi_eeprom_slave
    import twi_ee_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic       cmd_load, cmd_put, cmd_get, cmd_launch, a8, busy;
    logic [7:0] rx_byte, rd_data;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_ee_proto proto_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
        .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .cmd_load(cmd_load),
        .cmd_put(cmd_put), .cmd_get(cmd_get), .cmd_launch(cmd_launch),
        .a8(a8), .rx_byte(rx_byte)
    );

    twi_ee_store #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) store_i (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_put(cmd_put),
        .cmd_get(cmd_get), .cmd_launch(cmd_launch), .a8(a8), .wbyte(rx_byte),
        .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: rtl/twi_eeprom_checker.sv
// Protocol checks for twi_eeprom_slave, bound to every instance of the top.
// Observes the pull-down, the synchronised clock level, stop events and the store.
module twi_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_lvl,
    input logic stop_evt,
    input logic busy,
    input logic cmd_get
);
    // R5: no acknowledge or data is driven while the write cycle runs
    assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5: a write cycle only starts right after a stop
    assert_launch_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R5: no read byte is fetched from the array during a write cycle
    assert_no_read_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_get |-> !busy);

    // R11: the pull-down becomes active only while the bus clock is low
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R11: a stop releases the data line
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
endmodule

bind twi_eeprom_slave twi_eeprom_checker chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
    .stop_evt(stop_evt), .busy(busy), .cmd_get(cmd_get)
);

// File: tb/twi_eeprom_slave_tb_top.sv
// Bus-master bench for twi_eeprom_slave with a bench-side memory model.
module twi_eeprom_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;      // system clocks per quarter bus bit
    localparam int WR_CYC     = 1000;
    localparam int PAGE       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic bus_sda;
    logic done = 1'b0;

    logic [7:0] model [512];
    int ptr_m = 0;
    int n_vec = 0;
    int n_bad = 0;

    assign bus_sda = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_eeprom_slave #(.PAGE_BYTES(PAGE), .WRITE_CYCLES(WR_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b;  wq(Q);
        m_scl = 1'b1; wq(Q);
        s = bus_sda; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rx_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(!mack, s);
    endtask

    task automatic sw_reset();
        logic s;
        bus_start();
        for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
        bus_start();
    endtask

    function automatic logic [7:0] dev(input logic rd, input logic hi);
        return {4'b1010, 2'b00, hi, rd};
    endfunction

    task automatic poll(output logic ack);
        bus_start();
        tx_byte(8'hA0, ack);
        bus_stop();
    endtask

    task automatic wait_ready();
        logic a;
        int n = 0;
        do begin
            poll(a);
            n++;
        end while (!a && n < 50);
        check("R5 ready after write cycle", int'(a), 1);
    endtask

    // Page write of n bytes from addr; model updated with in-page wrap (R4, R6).
    task automatic write_seq(input int addr, input int n, input int seed, input bit rst_mid);
        logic a;
        logic [7:0] d;
        int loc;
        bus_start();
        tx_byte(dev(1'b0, addr[8]), a);
        check("R3 write device ack", int'(a), 1);
        tx_byte(addr[7:0], a);
        check("R3 word address ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            d = 8'((addr + k * 29 + seed * 53) ^ 8'h5A);
            tx_byte(d, a);
            check("R4 data ack", int'(a), 1);
            loc = (addr & 32'h1F0) | ((addr + k) & 32'hF);
            model[loc] = d;
        end
        bus_stop();
        ptr_m = (addr & 32'h1F0) | ((addr + n) & 32'hF);
        if (rst_mid) begin
            sw_reset();
            bus_stop();
        end
        poll(a);
        check(rst_mid ? "R10 still busy after reset" : "R5 busy nack", int'(a), 0);
        wait_ready();
    endtask

    // Read n bytes; random read loads addr first, read device byte carries a flipped A8 (R7).
    task automatic read_seq(input bit rnd, input int addr, input int n, input string tag);
        logic a;
        logic [7:0] d;
        if (rnd) begin
            bus_start();
            tx_byte(dev(1'b0, addr[8]), a);
            check("R3 dummy write ack", int'(a), 1);
            tx_byte(addr[7:0], a);
            check("R3 dummy word ack", int'(a), 1);
            ptr_m = addr;
        end
        bus_start();
        tx_byte(dev(1'b1, ~ptr_m[8]), a);
        check("R7 read device ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(k < n - 1, d);
            check(tag, int'(d), int'(model[ptr_m]));
            ptr_m = (ptr_m + 1) % 512;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        logic s;
        int ca [6];
        int cn [6];
        ca = '{32'h1F3, 32'h05A, 32'h000, 32'h1F0, 32'h0A7, 32'h0AF};
        cn = '{1, 20, 16, 16, 5, 1};
        for (int i = 0; i < 512; i++) model[i] = 8'h00;

        wq(5);
        rst_n = 1'b1;
        wq(5);
        check("R1 released after reset", int'(sda_oe), 0);
        poll(a);
        check("R1 idle after reset", int'(a), 1);

        // R2: sweep upper six device-byte bits, low bits 00
        for (int v = 0; v < 64; v++) begin
            bus_start();
            tx_byte({6'(v), 2'b00}, a);
            bus_stop();
            check("R2 device match", int'(a), int'(v == 6'b101000));
        end

        // R4/R6/R8: page writes at several offsets and lengths
        for (int i = 0; i < 6; i++) begin
            write_seq(ca[i], cn[i], i, 1'b0);
            read_seq(1'b0, 0, 1, "R6 pointer after write");
            read_seq(1'b1, ca[i] & 32'h1F0, PAGE, "R8 page readback");
        end

        // R7: sequential read across the top of the array
        read_seq(1'b1, 32'h1FE, 4, "R7 wrap 511 to 0");

        // R3: dummy write then stop, no write cycle, pointer loaded with A8
        bus_start();
        tx_byte(dev(1'b0, 1'b1), a);
        tx_byte(8'h22, a);
        bus_stop();
        poll(a);
        check("R3 no write cycle after dummy write", int'(a), 1);
        ptr_m = 32'h122;
        read_seq(1'b0, 0, 1, "R3 pointer loaded");

        // R10: partial command dropped by software reset
        bus_start();
        tx_byte(dev(1'b0, 1'b0), a);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        sw_reset();
        bus_stop();
        read_seq(1'b0, 0, 1, "R10 pointer unchanged");

        // R9: data followed by repeated start is dropped
        bus_start();
        tx_byte(dev(1'b0, 1'b0), a);
        tx_byte(8'hA7, a);
        tx_byte(8'hC3, a);
        bus_start();
        tx_byte(dev(1'b0, 1'b0), a);
        check("R9 restart device ack", int'(a), 1);
        tx_byte(8'h40, a);
        bus_stop();
        poll(a);
        check("R9 no write cycle", int'(a), 1);
        read_seq(1'b1, 32'h0A7, 1, "R9 dropped data");

        // R10: software reset during a write cycle leaves the cycle intact
        write_seq(32'h133, 3, 7, 1'b1);
        read_seq(1'b1, 32'h133, 3, "R10 write completed");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule